// File: doc/BRIEF.md
# Self-Timed Program Busy Controller

This block sits behind the serial command decoder of a small word-organised non-volatile store. Once a write-type command (single word, page of words, or whole-array fill) has been completely shifted in, the decoder raises a commit request and hands over the target address, a slot mask and the buffered words. The controller holds them and waits for chip select to drop. That falling edge launches a self-timed programming cycle. The cycle is a programmable count of system clocks that models the erase/write time, followed by a burst of array write strobes. If any serial clock edge arrives between the commit request and the chip-select fall, the command is discarded.

While chip select is high after a cycle has started, the controller drives the serial data output with the cycle status. It drives 0 while programming is still running and 1 once the array has been updated. That ready level stays on the pin for as long as it takes to see the start bit of the next command. With chip select low the output is never enabled. A separate monitor measures each chip-select low period and pulses an error flag when the gap between commands is too short.

The array write port has no back-pressure: the array is assumed to accept one word per clock. This is why the port is a plain strobe rather than a valid/ready pair. All inputs are synchronous to `clk`. `cs` is sampled as a level, and `sk_rise` and `start_bit` are one-cycle pulses from the decoder.

Top module: `pgm_busy_ctrl`

## Requirements
- R1: During and straight after reset, `do_oe`, `arr_wr_en` and `cs_gap_err` are 0 and `status_ready` is 1.
- R2: A commit request is taken only while `cs` is high and no cycle is running, and no programming starts while `cs` stays high. The cycle begins at the first clock edge that samples `cs` low after the request.
- R3: A `sk_rise` pulse after an accepted commit request and before the chip-select fall cancels the command: no array write happens and `do_oe` stays 0.
- R4: Counting the edge that samples the chip-select fall as edge 0, `do_bit` reads 0 after edges 0 to P+N-1 and 1 from edge P+N onwards. P is PROG_CYCLES. N is 2^ADDR_W for a fill and PAGE_WORDS for the other kinds.
- R5: `do_oe` is 0 whenever `cs` is low, whatever the programming status.
- R6: The ready level stays driven while `cs` is high, until a `start_bit` pulse is received. From the edge that samples that pulse, `do_oe` is 0.
- R7: No array write strobe is issued during the P-cycle count. All writes fall in the N cycles after edge P.
- R8: `commit_kind` 2'b00 (single) writes exactly one word to `commit_addr`. The word is taken from slot `commit_addr[PG_W-1:0]` of `commit_data`, where slot s occupies bits [s*DATA_W +: DATA_W].
- R9: `commit_kind` 2'b01 (page) writes slot s to address {commit_addr[ADDR_W-1:PG_W], s} for each set bit s of `commit_mask`. It leaves addresses of clear bits untouched.
- R10: `commit_kind` 2'b10 (fill) writes slot 0 of `commit_data` to every one of the 2^ADDR_W addresses in one cycle.
- R11: If `cs` rises after being sampled low on fewer than MIN_CS_LOW edges, `cs_gap_err` is 1 for the one cycle after the rising edge is sampled. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip-select level |
| sk_rise | input | 1 | Pulse: serial clock rising edge seen |
| start_bit | input | 1 | Pulse: start bit of a new command received |
| commit_req | input | 1 | Pulse: write-type command fully shifted in |
| commit_kind | input | 2 | 00 single, 01 page, 10 fill |
| commit_addr | input | ADDR_W | Target word address |
| commit_mask | input | PAGE_WORDS | Page slots holding new data |
| commit_data | input | PAGE_WORDS*DATA_W | Buffered words, slot s at [s*DATA_W +: DATA_W] |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_addr | output | ADDR_W | Array write address |
| arr_wr_data | output | DATA_W | Array write data |
| status_ready | output | 1 | 1 when no programming cycle is running |
| do_bit | output | 1 | Status level for the serial data output |
| do_oe | output | 1 | Output enable for the serial data pin |
| cs_gap_err | output | 1 | One-cycle pulse on a too-short chip-select low time |

## Verification
Busy status is due exactly P+N edges after the edge that samples the chip-select fall. The bench counts edges from that point and samples on the falling clock edge just after edge P+N-1 and edge P+N, so both sides of the transition are pinned. Write strobes are registered by the bench at each rising edge. The write count is checked to still be zero after edge P, and the array image is compared only after the burst has finished. The gap error is due in the cycle after the rising chip-select edge is sampled and is checked there and one cycle later. The output-enable drop is checked one edge after the start-bit pulse.

// File: rtl/pgm_busy_pkg.sv
`timescale 1ns/1ps
package pgm_busy_pkg;
  typedef enum logic [1:0] {
    WK_SINGLE = 2'b00,
    WK_PAGE   = 2'b01,
    WK_ALL    = 2'b10
  } wr_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_COUNT  = 2'b01,
    ST_COMMIT = 2'b10
  } pgm_state_e;
endpackage

// File: rtl/pgm_delay_timer.sv
`timescale 1ns/1ps
module pgm_delay_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          run;

  assign busy = run;
  assign done = run && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      if (done) run <= 1'b0;
      else      cnt <= cnt + 1'b1;
    end
  end

  // the count window ends exactly once per start
  assert_done_ends_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !run);
endmodule

// File: rtl/pgm_commit_seq.sv
`timescale 1ns/1ps
module pgm_commit_seq
  import pgm_busy_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  wr_kind_e                     kind,
  input  logic [ADDR_W-1:0]            base,
  input  logic [PAGE_WORDS-1:0]        mask,
  input  logic [PAGE_WORDS*DATA_W-1:0] words,
  output logic                         wr_en,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [DATA_W-1:0]            wr_data,
  output logic                         done
);
  localparam int PG_W = $clog2(PAGE_WORDS);
  localparam int SPAN = 1 << ADDR_W;

  logic              run;
  logic [ADDR_W-1:0] idx;
  logic [PG_W-1:0]   slot;
  logic              last;

  assign slot = idx[PG_W-1:0];
  assign last = (kind == WK_ALL) ? (idx == ADDR_W'(SPAN - 1))
                                 : (idx == ADDR_W'(PAGE_WORDS - 1));
  assign done = run && last;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = {base[ADDR_W-1:PG_W], slot};
    wr_data = words[slot*DATA_W +: DATA_W];
    if (run) begin
      unique case (kind)
        WK_ALL: begin
          wr_en   = 1'b1;
          wr_addr = idx;
          wr_data = words[DATA_W-1:0];
        end
        WK_SINGLE: wr_en = (slot == base[PG_W-1:0]);
        default:   wr_en = mask[slot];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      idx <= '0;
    end else if (start) begin
      run <= 1'b1;
      idx <= '0;
    end else if (run) begin
      if (last) run <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  // a fill keeps one word on the write bus for the whole burst
  assert_fill_word_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run && (kind == WK_ALL) && (idx != '0) |-> $stable(wr_data));
  // the burst ends after its final slot
  assert_burst_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !run);
endmodule

// File: rtl/pgm_cs_gap_mon.sv
`timescale 1ns/1ps
module pgm_cs_gap_mon #(
  parameter int MIN_LOW = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  output logic err
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic          cs_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      low_cnt <= CW'(MIN_LOW);
      err     <= 1'b0;
    end else begin
      cs_q <= cs;
      err  <= 1'b0;
      if (!cs) begin
        if (cs_q)                         low_cnt <= CW'(1);
        else if (low_cnt != CW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
      end else if (!cs_q) begin
        err <= (low_cnt < CW'(MIN_LOW));
      end
    end
  end

  // the flag is a single-cycle pulse
  assert_err_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

// File: rtl/pgm_busy_ctrl.sv
`timescale 1ns/1ps
module pgm_busy_ctrl
  import pgm_busy_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PAGE_WORDS  = 4,
  parameter int PROG_CYCLES = 500000,
  parameter int MIN_CS_LOW  = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs,
  input  logic                         sk_rise,
  input  logic                         start_bit,
  input  logic                         commit_req,
  input  logic [1:0]                   commit_kind,
  input  logic [ADDR_W-1:0]            commit_addr,
  input  logic [PAGE_WORDS-1:0]        commit_mask,
  input  logic [PAGE_WORDS*DATA_W-1:0] commit_data,
  output logic                         arr_wr_en,
  output logic [ADDR_W-1:0]            arr_wr_addr,
  output logic [DATA_W-1:0]            arr_wr_data,
  output logic                         status_ready,
  output logic                         do_bit,
  output logic                         do_oe,
  output logic                         cs_gap_err
);
  localparam int WORDS_W = PAGE_WORDS * DATA_W;

  pgm_state_e          st;
  logic                cs_q, armed, show;
  wr_kind_e            kind_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [PAGE_WORDS-1:0] mask_q;
  logic [WORDS_W-1:0]  words_q;
  logic                cs_fall, go, busy;
  logic                t_busy, t_done, s_done;

  assign cs_fall = cs_q && !cs;
  assign go      = (st == ST_IDLE) && armed && cs_fall;
  assign busy    = (st != ST_IDLE);

  assign status_ready = !busy;
  assign do_bit       = !busy;
  assign do_oe        = show && cs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cs_q    <= 1'b0;
      armed   <= 1'b0;
      show    <= 1'b0;
      kind_q  <= WK_SINGLE;
      addr_q  <= '0;
      mask_q  <= '0;
      words_q <= '0;
    end else begin
      cs_q <= cs;
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            st    <= ST_COUNT;
            armed <= 1'b0;
            show  <= 1'b1;
          end else if (commit_req && cs) begin
            armed   <= 1'b1;
            kind_q  <= wr_kind_e'(commit_kind);
            addr_q  <= commit_addr;
            mask_q  <= commit_mask;
            words_q <= commit_data;
          end else if (sk_rise) begin
            armed <= 1'b0;
          end
          if (start_bit && !go) show <= 1'b0;
        end
        ST_COUNT:  if (t_done) st <= ST_COMMIT;
        ST_COMMIT: if (s_done) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  pgm_delay_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(go), .busy(t_busy), .done(t_done)
  );

  pgm_commit_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(t_done), .kind(kind_q), .base(addr_q),
    .mask(mask_q), .words(words_q), .wr_en(arr_wr_en), .wr_addr(arr_wr_addr),
    .wr_data(arr_wr_data), .done(s_done)
  );

  pgm_cs_gap_mon #(.MIN_LOW(MIN_CS_LOW)) u_gap (
    .clk(clk), .rst_n(rst_n), .cs(cs), .err(cs_gap_err)
  );

  // a cycle only starts from a sampled chip-select fall
  assert_start_on_cs_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs));
  // the array is untouched while the delay is counted
  assert_no_write_counting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    t_busy |-> !arr_wr_en);
  // write strobes come only from the commit phase
  assert_write_in_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> (st == ST_COMMIT));
  // ready indication persists until a start bit
  assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    show && !busy && !start_bit |=> show);
endmodule

// File: tb/test_pgm_busy_ctrl.sv
`timescale 1ns/1ps
module test_pgm_busy_ctrl;
  localparam int AW = 6, DW = 16, PW = 4, P = 8, ML = 3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [5:0]  addr;
    logic [3:0]  mask;
    logic [15:0] seed;
    logic        cancel;
  } txn_t;

  localparam txn_t TXN [6] = '{
    '{kind: 2'b00, addr: 6'h05, mask: 4'b0000, seed: 16'hA5A5, cancel: 1'b0},
    '{kind: 2'b01, addr: 6'h2D, mask: 4'b1011, seed: 16'h3C3C, cancel: 1'b0},
    '{kind: 2'b01, addr: 6'h10, mask: 4'b1111, seed: 16'h0F0F, cancel: 1'b0},
    '{kind: 2'b00, addr: 6'h3F, mask: 4'b0000, seed: 16'h1234, cancel: 1'b1},
    '{kind: 2'b10, addr: 6'h00, mask: 4'b0000, seed: 16'hBEEF, cancel: 1'b0},
    '{kind: 2'b00, addr: 6'h05, mask: 4'b0000, seed: 16'h7777, cancel: 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk_rise = 1'b0, start_bit = 1'b0;
  logic commit_req = 1'b0;
  logic [1:0] commit_kind = '0;
  logic [AW-1:0] commit_addr = '0;
  logic [PW-1:0] commit_mask = '0;
  logic [PW*DW-1:0] commit_data = '0;
  logic arr_wr_en, status_ready, do_bit, do_oe, cs_gap_err;
  logic [AW-1:0] arr_wr_addr;
  logic [DW-1:0] arr_wr_data;

  int checks = 0, errors = 0, wr_cnt = 0;
  logic [DW-1:0] mem_dut [64];
  logic [DW-1:0] mem_ref [64];

  always #5 clk = ~clk;

  pgm_busy_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(PW), .PROG_CYCLES(P),
                  .MIN_CS_LOW(ML)) i_pgm_busy_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise), .start_bit(start_bit),
    .commit_req(commit_req), .commit_kind(commit_kind), .commit_addr(commit_addr),
    .commit_mask(commit_mask), .commit_data(commit_data), .arr_wr_en(arr_wr_en),
    .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data), .status_ready(status_ready),
    .do_bit(do_bit), .do_oe(do_oe), .cs_gap_err(cs_gap_err)
  );

  always @(posedge clk) begin
    if (arr_wr_en) begin
      mem_dut[arr_wr_addr] <= arr_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [15:0] seed, input int s);
    return seed + 16'(s) * 16'h0101;
  endfunction

  task automatic run_txn(input txn_t t);
    logic [PW*DW-1:0] dat;
    int n, expw, bad, k;
    string rq;
    for (int s = 0; s < PW; s++) dat[s*DW +: DW] = word_of(t.seed, s);
    n = (t.kind == 2'b10) ? 64 : PW;
    if (t.kind == 2'b10)      begin expw = 64; rq = "R10"; end
    else if (t.kind == 2'b00) begin expw = 1;  rq = "R8";  end
    else                      begin expw = $countones(t.mask); rq = "R9"; end
    if (t.cancel) begin expw = 0; rq = "R3"; end

    @(negedge clk); cs = 1'b1; wr_cnt = 0;
    @(negedge clk);
    commit_req = 1'b1; commit_kind = t.kind; commit_addr = t.addr;
    commit_mask = t.mask; commit_data = dat;
    @(negedge clk); commit_req = 1'b0; sk_rise = t.cancel;
    @(negedge clk); sk_rise = 1'b0;
    repeat (2) @(negedge clk);
    chk(!do_oe && wr_cnt == 0 && status_ready, "R2", "idle while cs high", {do_oe, 8'(wr_cnt)}, 0);
    cs = 1'b0;
    for (k = 0; k < n + P + 6; k++) begin
      @(negedge clk);
      if (k == 1) chk(!do_oe, "R5", "oe with cs low", do_oe, 0);
      if (k == 2) cs = 1'b1;
      if (k == 3) chk(!cs_gap_err, "R11", "no gap error", cs_gap_err, 0);
      if (!t.cancel) begin
        if (k == P) chk(wr_cnt == 0, "R7", "writes during count", wr_cnt, 0);
        if (k == P + n - 1) chk(do_oe && !do_bit, "R4", "busy level", {do_oe, do_bit}, 2'b10);
        if (k == P + n)     chk(do_oe && do_bit, "R4", "ready level", {do_oe, do_bit}, 2'b11);
        if (k == P + n + 5) chk(do_oe && do_bit, "R6", "ready held", {do_oe, do_bit}, 2'b11);
      end else if (k == P + n) begin
        chk(!do_oe, "R3", "cancelled, oe", do_oe, 0);
      end
    end
    start_bit = 1'b1;
    @(negedge clk); start_bit = 1'b0;
    chk(!do_oe, "R6", "oe after start bit", do_oe, 0);
    cs = 1'b0;
    repeat (3) @(negedge clk);

    if (!t.cancel) begin
      if (t.kind == 2'b10)
        for (int a = 0; a < 64; a++) mem_ref[a] = word_of(t.seed, 0);
      else if (t.kind == 2'b00)
        mem_ref[t.addr] = word_of(t.seed, int'(t.addr[1:0]));
      else
        for (int s = 0; s < PW; s++)
          if (t.mask[s]) mem_ref[{t.addr[5:2], 2'(s)}] = word_of(t.seed, s);
    end
    bad = 0;
    for (int a = 0; a < 64; a++) if (mem_dut[a] !== mem_ref[a]) bad++;
    chk(bad == 0, rq, "array image mismatches", bad, 0);
    chk(wr_cnt == expw, rq, "write strobe count", wr_cnt, expw);
  endtask

  initial begin
    for (int a = 0; a < 64; a++) begin mem_dut[a] = '0; mem_ref[a] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!do_oe && !arr_wr_en && !cs_gap_err && status_ready, "R1", "in reset",
        {do_oe, arr_wr_en, cs_gap_err, status_ready}, 4'b0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!do_oe && !arr_wr_en && !cs_gap_err && status_ready, "R1", "after reset",
        {do_oe, arr_wr_en, cs_gap_err, status_ready}, 4'b0001);

    for (int i = 0; i < 6; i++) run_txn(TXN[i]);

    // R11: one-cycle chip-select low pulse is too short
    @(negedge clk); cs = 1'b1;
    repeat (2) @(negedge clk);
    cs = 1'b0;
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
    chk(cs_gap_err, "R11", "short gap flagged", cs_gap_err, 1);
    @(negedge clk);
    chk(!cs_gap_err, "R11", "flag lasts one cycle", cs_gap_err, 0);
    chk(!do_oe, "R6", "no status without a cycle", do_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule